// File: doc/BRIEF.md
# Serial Power-Device Register Access Engine

This block sits between a host bus and a serial link to a power-management device. Software writes one 32-bit command word to start a single 16-bit register read or write. The engine hands the command to a serial back end through a request/acknowledge handshake. Progress is reported in a status word, which holds the state code, an init-done flag, a sticky error flag and the last read data.

A write goes back to idle once the back end accepts it. A read behaves differently. After the back end accepts it, the engine waits for a response that carries data. It then parks with the data held until software writes 1 to a separate valid-clear register. Before software issues any command, it must see init-done set and the state at idle.

States and transitions:
- IDLE goes to REQ when an accepted command is written.
- REQ goes to IDLE on acknowledge for a write.
- REQ goes to WAIT_DATA on acknowledge for a read.
- WAIT_DATA goes to WAIT_CLR when the response is valid.
- WAIT_CLR goes to IDLE when a valid-clear write with bit 0 set arrives.

Top module: `pmic_access_top`

## Requirements
- R1: After reset, the status word reads 0: state IDLE (code 0), read data 0, init-done 0, error 0. Status layout: bits [15:0] hold the read data, [18:16] the state, bit 19 init-done and bit 20 the sticky error.
- R2: Init-done goes high the cycle after the `init_done_in` pin is seen high, and stays high until reset even if the pin later drops.
- R3: A command written while init-done is 0 is dropped. No request is raised and the state stays IDLE.
- R4: Command word layout: bit 31 is 1 for a write and 0 for a read, bits [30:16] hold the halfword address, and bits [15:0] hold the write data. An accepted command raises `be_req` in the next cycle, with `be_write`, `be_addr` and `be_wdata` taken from those fields. The state code becomes REQ (1).
- R5: `be_req` stays high, and its fields stay stable, until the first cycle in which `be_ack` is seen.
- R6: A write returns to IDLE in the cycle after acknowledge and never enters a wait state.
- R7: A read goes to WAIT_DATA (2) after acknowledge. It moves to WAIT_CLR (3) only in the cycle after `be_rvalid`, and captures `be_rdata` into status bits [15:0] at that point.
- R8: In WAIT_CLR, the state and the read data hold until a valid-clear write with bit 0 = 1 arrives. The next cycle, the state is IDLE.
- R9: A valid-clear write outside WAIT_CLR, or one with bit 0 = 0, has no effect.
- R10: A command written while the state is not IDLE is ignored and sets the sticky error bit (status bit 20). That bit is cleared only by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_done_in | input | 1 | Device ready indication, latched high |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_data | input | 32 | Command word |
| clr_wr | input | 1 | Valid-clear register write strobe |
| clr_data | input | 1 | Valid-clear write data bit 0 |
| status | output | 32 | Status word |
| be_req | output | 1 | Back-end request |
| be_write | output | 1 | Back-end direction, 1 = write |
| be_addr | output | 15 | Back-end halfword address |
| be_wdata | output | 16 | Back-end write data |
| be_ack | input | 1 | Back-end request accepted |
| be_rvalid | input | 1 | Back-end read response valid |
| be_rdata | input | 16 | Back-end read response data |

## Verification
Any wrong state would show within one cycle, because the state code is exported directly in status bits [18:16]. A missed transition or a skipped wait state would also show on `be_req` or on the held read data in the same cycle. Errors in accepting commands would show one cycle after the write: a spurious or missing request, or a sticky error bit that sets when it should not. Read-data corruption would show in the cycle after `be_rvalid`, and it would persist across the whole WAIT_CLR hold.

// File: rtl/pmic_access_pkg.sv
package pmic_access_pkg;
    localparam int DATA_W  = 16;
    localparam int ADDR_W  = 15;
    localparam int STATE_W = 3;
    localparam int STAT_W  = 32;

    localparam int ST_DATA_LSB  = 0;
    localparam int ST_STATE_LSB = 16;
    localparam int ST_INIT_BIT  = 19;
    localparam int ST_ERR_BIT   = 20;

    localparam int CMD_WR_BIT   = 31;
    localparam int CMD_ADDR_LSB = 16;

    typedef enum logic [STATE_W-1:0] {
        S_IDLE      = 3'd0,
        S_REQ       = 3'd1,
        S_WAIT_DATA = 3'd2,
        S_WAIT_CLR  = 3'd3
    } acc_state_e;

    typedef struct packed {
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } acc_cmd_t;
endpackage

// File: rtl/pmic_cmd_decode.sv
module pmic_cmd_decode
    import pmic_access_pkg::*;
(
    input  logic        cmd_wr,
    input  logic [31:0] cmd_data,
    input  logic        init_done,
    input  acc_state_e  state,
    output logic        accept,
    output logic        reject_busy,
    output acc_cmd_t    cmd
);
    always_comb begin
        cmd.write   = cmd_data[CMD_WR_BIT];
        cmd.addr    = cmd_data[CMD_ADDR_LSB +: ADDR_W];
        cmd.wdata   = cmd_data[DATA_W-1:0];
        accept      = cmd_wr && init_done && (state == S_IDLE);
        reject_busy = cmd_wr && init_done && (state != S_IDLE);
    end
endmodule

// File: rtl/pmic_access_fsm.sv
module pmic_access_fsm
    import pmic_access_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  acc_cmd_t          cmd_in,
    input  logic              clr_wr,
    input  logic              clr_data,
    input  logic              be_ack,
    input  logic              be_rvalid,
    input  logic [DATA_W-1:0] be_rdata,
    output acc_state_e        state,
    output acc_cmd_t          cmd_q,
    output logic [DATA_W-1:0] rdata_q,
    output logic              be_req
);
    acc_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:      if (accept) nxt = S_REQ;
            S_REQ:       if (be_ack) nxt = cmd_q.write ? S_IDLE : S_WAIT_DATA;
            S_WAIT_DATA: if (be_rvalid) nxt = S_WAIT_CLR;
            S_WAIT_CLR:  if (clr_wr && clr_data) nxt = S_IDLE;
            default:     nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            cmd_q   <= '0;
            rdata_q <= '0;
        end else begin
            state <= nxt;
            if (state == S_IDLE && accept) cmd_q <= cmd_in;
            if (state == S_WAIT_DATA && be_rvalid) rdata_q <= be_rdata;
        end
    end

    always_comb be_req = (state == S_REQ);
endmodule

// File: rtl/pmic_status_reg.sv
module pmic_status_reg
    import pmic_access_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_done_in,
    input  logic              reject_busy,
    input  acc_state_e        state,
    input  logic [DATA_W-1:0] rdata_q,
    output logic              init_done,
    output logic [STAT_W-1:0] status
);
    logic err_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            init_done <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            if (init_done_in) init_done <= 1'b1;
            if (reject_busy)  err_q     <= 1'b1;
        end
    end

    always_comb begin
        status = '0;
        status[ST_DATA_LSB +: DATA_W]   = rdata_q;
        status[ST_STATE_LSB +: STATE_W] = state;
        status[ST_INIT_BIT]             = init_done;
        status[ST_ERR_BIT]              = err_q;
    end
endmodule

// File: rtl/pmic_access_top.sv
module pmic_access_top
    import pmic_access_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        init_done_in,
    input  logic        cmd_wr,
    input  logic [31:0] cmd_data,
    input  logic        clr_wr,
    input  logic        clr_data,
    output logic [31:0] status,
    output logic        be_req,
    output logic        be_write,
    output logic [14:0] be_addr,
    output logic [15:0] be_wdata,
    input  logic        be_ack,
    input  logic        be_rvalid,
    input  logic [15:0] be_rdata
);
    logic       init_done, accept, reject_busy;
    acc_cmd_t   cmd_dec, cmd_q;
    acc_state_e state;
    logic [DATA_W-1:0] rdata_q;

    pmic_cmd_decode u_dec (
        .cmd_wr(cmd_wr), .cmd_data(cmd_data), .init_done(init_done),
        .state(state), .accept(accept), .reject_busy(reject_busy), .cmd(cmd_dec)
    );

    pmic_access_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .accept(accept), .cmd_in(cmd_dec),
        .clr_wr(clr_wr), .clr_data(clr_data), .be_ack(be_ack),
        .be_rvalid(be_rvalid), .be_rdata(be_rdata), .state(state),
        .cmd_q(cmd_q), .rdata_q(rdata_q), .be_req(be_req)
    );

    pmic_status_reg u_stat (
        .clk(clk), .rst_n(rst_n), .init_done_in(init_done_in),
        .reject_busy(reject_busy), .state(state), .rdata_q(rdata_q),
        .init_done(init_done), .status(status)
    );

    always_comb begin
        be_write = cmd_q.write;
        be_addr  = cmd_q.addr;
        be_wdata = cmd_q.wdata;
    end
endmodule

// File: rtl/pmic_access_checker.sv
module pmic_access_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        init_done_in,
    input logic        cmd_wr,
    input logic        clr_wr,
    input logic        clr_data,
    input logic [31:0] status,
    input logic        be_req,
    input logic        be_write,
    input logic [14:0] be_addr,
    input logic [15:0] be_wdata,
    input logic        be_ack,
    input logic        be_rvalid
);
    logic [2:0] st;
    assign st = status[18:16];

    assert_init_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        status[19] |=> status[19]);
    assert_no_cmd_pre_init_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !status[19] && st == 3'd0) |=> (st == 3'd0 && !be_req));
    assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (be_req && !be_ack) |=> (be_req && $stable(be_addr) && $stable(be_wdata) && $stable(be_write)));
    assert_write_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (be_req && be_ack && be_write) |=> (st == 3'd0));
    assert_wait_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 3'd2 && !be_rvalid) |=> (st == 3'd2));
    assert_hold_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 3'd3 && !(clr_wr && clr_data)) |=> (st == 3'd3 && $stable(status[15:0])));
    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        status[20] |=> status[20]);
    assert_state_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        st <= 3'd3);
endmodule

bind pmic_access_top pmic_access_checker u_chk (
    .clk(clk), .rst_n(rst_n), .init_done_in(init_done_in), .cmd_wr(cmd_wr),
    .clr_wr(clr_wr), .clr_data(clr_data), .status(status), .be_req(be_req),
    .be_write(be_write), .be_addr(be_addr), .be_wdata(be_wdata),
    .be_ack(be_ack), .be_rvalid(be_rvalid)
);

// File: tb/tb_pmic_access_top.sv
`timescale 1ns/1ps
module tb_pmic_access_top;
    logic        clk = 0, rst_n = 0;
    logic        init_done_in = 0, cmd_wr = 0, clr_wr = 0, clr_data = 0;
    logic [31:0] cmd_data = 0;
    logic [31:0] status;
    logic        be_req, be_write, be_ack = 0, be_rvalid = 0;
    logic [14:0] be_addr;
    logic [15:0] be_wdata, be_rdata = 0;
    int n_chk = 0, n_bad = 0;

    always #5 clk = ~clk;

    pmic_access_top dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive after posedge, sample at negedge
    task automatic tick(); @(posedge clk); #1; endtask
    task automatic smp();  @(negedge clk); endtask

    task automatic write_cmd(input logic [31:0] w);
        cmd_wr = 1; cmd_data = w; tick(); cmd_wr = 0;
    endtask

    function automatic logic [31:0] stw(int st, logic init, logic err, logic [15:0] d);
        return {11'd0, err, init, st[2:0], d};
    endfunction

    task automatic t_reset();
        smp(); chk("R1", status, 32'h0);
        chk("R1", {31'd0, be_req}, 32'd0);
    endtask

    task automatic t_preinit();
        write_cmd(32'h8005_1234);
        smp(); chk("R3", status, stw(0, 0, 0, 0));
        chk("R3", {31'd0, be_req}, 0);
        tick();
    endtask

    task automatic t_init();
        init_done_in = 1; tick(); init_done_in = 0;
        smp(); chk("R2", {31'd0, status[19]}, 1);
        tick(); tick(); smp(); chk("R2", {31'd0, status[19]}, 1);
        tick();
    endtask

    task automatic t_write(input logic [14:0] a, input logic [15:0] d, int wait_ack);
        write_cmd({1'b1, a, d});
        smp();
        chk("R4", status[18:16], 1);
        chk("R4", {be_req, be_write, be_addr, be_wdata}, {1'b1, 1'b1, a, d});
        for (int i = 0; i < wait_ack; i++) begin
            tick(); smp(); chk("R5", {be_req, be_addr, be_wdata}, {1'b1, a, d});
        end
        be_ack = 1; tick(); be_ack = 0;
        smp(); chk("R6", status[18:16], 0);
        chk("R6", {31'd0, be_req}, 0);
        tick();
    endtask

    task automatic t_read(input logic [14:0] a, input logic [15:0] rd, input logic [15:0] old);
        write_cmd({1'b0, a, 16'hFFFF});
        smp(); chk("R4", {be_req, be_write, be_addr}, {1'b1, 1'b0, a});
        be_ack = 1; tick(); be_ack = 0;
        smp(); chk("R7", status[18:16], 2);
        tick(); tick(); smp(); chk("R7", status[18:16], 2);
        chk("R7", status[15:0], old);
        be_rvalid = 1; be_rdata = rd; tick(); be_rvalid = 0; be_rdata = 16'hDEAD;
        smp(); chk("R7", status[18:16], 3); chk("R7", status[15:0], rd);
        clr_wr = 1; clr_data = 0; tick(); clr_wr = 0;
        smp(); chk("R9", status[18:16], 3);
        tick(); tick(); smp();
        chk("R8", status[18:16], 3); chk("R8", status[15:0], rd);
        clr_wr = 1; clr_data = 1; tick(); clr_wr = 0; clr_data = 0;
        smp(); chk("R8", status[18:16], 0); chk("R8", status[15:0], rd);
        tick();
    endtask

    task automatic t_stray_clear();
        clr_wr = 1; clr_data = 1; tick(); clr_wr = 0; clr_data = 0;
        smp(); chk("R9", status, stw(0, 1, 0, 16'h5A5A));
        tick();
    endtask

    task automatic t_busy();
        write_cmd({1'b1, 15'h0010, 16'h0001});
        smp(); chk("R10", {31'd0, status[20]}, 0);
        write_cmd({1'b1, 15'h0077, 16'h7777});
        smp(); chk("R10", {31'd0, status[20]}, 1);
        chk("R10", {be_addr, be_wdata}, {15'h0010, 16'h0001});
        be_ack = 1; tick(); be_ack = 0;
        smp(); chk("R10", status[18:16], 0);
        tick(); tick(); smp(); chk("R10", {31'd0, status[20]}, 1);
        chk("R10", {31'd0, be_req}, 0);
    endtask

    initial begin
        fork
            begin
                #3; tick(); tick(); rst_n = 1; tick();
                t_reset();
                tick();
                t_preinit();
                t_init();
                t_write(15'h0005, 16'h1234, 0);
                t_write(15'h7FFF, 16'hA5C3, 3);
                t_read(15'h0123, 16'h5A5A, 16'h0000);
                t_stray_clear();
                t_busy();
            end
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule